// File: doc/BRIEF.md
# Timer Capture, Compare and PWM Channel

This block is a single channel of a general-purpose timer. It watches a free-running counter value and a one-cycle overflow strobe, both shared with the rest of the timer. A six-bit control field chooses among three functions. In capture mode the channel records the counter value when its input pin shows a chosen edge. In compare mode it acts on its output pin when the counter equals a programmed value. With toggle-on-overflow added to compare, the channel produces pulse-width modulation. A buffered compare variant defers new compare values to the next overflow, so a running PWM period never sees a half-updated threshold.

Software reaches the channel through a two-word register port with plain write and read strobes. Word 0 holds the control bits and the channel flag. Word 1 holds the channel value, which is the compare threshold or the last captured count. These are control pins only. There is no valid/ready flow control, and every write takes effect on the clock edge where it is presented. The channel drives its pin level together with an output enable, which tells the port logic whether the timer or general-purpose I/O owns the pin.

Top module: `tmr_chan`

## Requirements
- R1: After reset the control field and the flag read as zero, `pin_o` is 0 and `pin_oe_o` is 0.
- R2: When edge bits `els` (control bits 1:0) are 00, `pin_oe_o` is 0. The pin level follows mode bit `msa` (control bit 2) one cycle after the control write.
- R3: When mode bits {`msb`,`msa`} (control bits 3:2) are 00, `els` selects capture. 01 captures on rising edges only, 10 on falling edges only, 11 on both. A capture copies `cnt_i` into word 1 and sets the flag. Edges not selected change neither the flag nor word 1.
- R4: The capture input passes through two synchronizing flops. A level applied before clock edge k is captured at edge k+2, using the `cnt_i` present at that edge.
- R5: When `msb`=0 and `msa`=1, a match between `cnt_i` and word 1 toggles the pin for `els` 01, clears it for 10 and sets it for 11. The pin is driven (`pin_oe_o`=1) whenever `els` is nonzero.
- R6: A compare match sets the flag in every compare mode (`msb` or `msa` set), including `els`=00, which is compare without pin action.
- R7: With `tov` (control bit 4) set, `ovf_i` toggles the pin in compare modes. In capture mode, `ovf_i` leaves the pin unchanged.
- R8: When `tov` is set and `ovf_i` coincides with a compare match, the pin toggles and the compare action is not applied.
- R9: When `msb`=1, writes to word 1 go to a hidden buffer. That buffer becomes the active compare value (and word 1 readback) only at the next `ovf_i`.
- R10: With `tov`=1, setting `fmax` (control bit 5) drives `pin_o` high from the cycle after the write. `pin_o` is released in the cycle after `fmax` is cleared. With `tov`=0, `fmax` has no effect.
- R11: The flag (word 0 bit 7) clears only when word 0 is written with bit 7 = 0 after a read of word 0 that returned the flag as 1. A new flag event in the same cycle wins.
- R12: Read data is combinational on `reg_addr_i`. Word 0 reads {flag, 0, fmax, tov, msb, msa, els}, zero-extended. Word 1 reads the channel value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CW | Shared counter value |
| ovf_i | input | 1 | Counter overflow strobe, one cycle |
| cap_i | input | 1 | Asynchronous capture input from the pin |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (used to arm the flag clear) |
| reg_addr_i | input | 1 | Word select: 0 control/flag, 1 channel value |
| reg_wdata_i | input | CW | Write data |
| reg_rdata_o | output | CW | Read data |
| pin_o | output | 1 | Channel output level |
| pin_oe_o | output | 1 | 1 when the timer owns the pin |
| flag_o | output | 1 | Channel flag |

## Verification
An overflow toggle and a compare action can land in the same cycle. To provoke this, the bench sets `tov`, drives `cnt_i` to the compare value and raises `ovf_i` on that same cycle. The compare action is chosen so that it disagrees with a toggle: clear from a low pin, or set from a high pin. The pin is judged on the cycle after that edge and must show the toggled level. The flag must still be set by the match. A second overlap, a buffered write arriving in the same window as an overflow, is checked by reading word 1 before and after the overflow.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  localparam int CTL_W  = 8;
  localparam int B_FLAG = 7;

  // control field, bit 0 first: els a/b, mode a/b, toggle-on-overflow, force max
  typedef struct packed {
    logic fmax;
    logic tov;
    logic msb;
    logic msa;
    logic elsb;
    logic elsa;
  } ctrl_t;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_TOG  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_SET  = 2'b11
  } act_e;
endpackage

// File: rtl/tmr_chan_sync.sv
module tmr_chan_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  // sh[0..STAGES-1] synchronizer, sh[STAGES] previous synchronized level
  logic [STAGES:0] sh;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh[g] <= 1'b0;
        else        sh[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh[g] <= 1'b0;
        else        sh[g] <= sh[g-1];
    end
  end

  assign rise_o =  sh[STAGES-1] & ~sh[STAGES];
  assign fall_o = ~sh[STAGES-1] &  sh[STAGES];
endmodule

// File: rtl/tmr_chan_val.sv
module tmr_chan_val #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buffered_i,
  input  logic          cap_load_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          wr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          ovf_i,
  output logic [CW-1:0] val_o
);
  logic [CW-1:0] shadow;
  logic          pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_o  <= '0;
      shadow <= '0;
      pend   <= 1'b0;
    end else begin
      if (buffered_i && ovf_i && pend) pend <= 1'b0;
      if (buffered_i && wr_i) begin
        shadow <= wdata_i;
        pend   <= 1'b1;
      end
      if (cap_load_i)                      val_o <= cnt_i;
      else if (!buffered_i && wr_i)        val_o <= wdata_i;
      else if (buffered_i && ovf_i && pend) val_o <= shadow;
    end
  end
endmodule

// File: rtl/tmr_chan_out.sv
module tmr_chan_out
  import tmr_chan_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t ctl_i,
  input  logic  oc_mode_i,
  input  logic  match_i,
  input  logic  ovf_i,
  output logic  lvl_o,
  output logic  pin_o,
  output logic  oe_o
);
  logic lvl_nxt;
  logic max_d;
  act_e act;

  assign act = act_e'({ctl_i.elsb, ctl_i.elsa});

  always_comb begin
    lvl_nxt = lvl_o;
    if (act == ACT_NONE)             lvl_nxt = ctl_i.msa;
    else if (!oc_mode_i)             lvl_nxt = lvl_o;
    else if (ctl_i.tov && ovf_i)     lvl_nxt = ~lvl_o;
    else if (match_i) begin
      case (act)
        ACT_TOG: lvl_nxt = ~lvl_o;
        ACT_CLR: lvl_nxt = 1'b0;
        ACT_SET: lvl_nxt = 1'b1;
        default: lvl_nxt = lvl_o;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_o <= 1'b0;
      max_d <= 1'b0;
    end else begin
      lvl_o <= lvl_nxt;
      max_d <= ctl_i.fmax;
    end
  end

  assign pin_o = (ctl_i.tov && max_d) ? 1'b1 : lvl_o;
  assign oe_o  = oc_mode_i && (act != ACT_NONE);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic          ovf_i,
  input  logic          cap_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic          reg_addr_i,
  input  logic [CW-1:0] reg_wdata_i,
  output logic [CW-1:0] reg_rdata_o,
  output logic          pin_o,
  output logic          pin_oe_o,
  output logic          flag_o
);
  localparam int PAD_W = CW - CTL_W;

  ctrl_t         ctl;
  logic          armed;
  logic          wr_ctl, wr_val, rd_ctl;
  logic          cap_mode, oc_mode, match, cap_hit;
  logic          rise, fall;
  logic          flag_clr;
  logic [CW-1:0] val;
  logic          pin_lvl;

  assign wr_ctl = reg_wr_i && !reg_addr_i;
  assign wr_val = reg_wr_i &&  reg_addr_i;
  assign rd_ctl = reg_rd_i && !reg_addr_i;

  assign cap_mode = !ctl.msb && !ctl.msa;
  assign oc_mode  = ctl.msb || ctl.msa;
  assign cap_hit  = cap_mode && ((ctl.elsa && rise) || (ctl.elsb && fall));
  assign match    = oc_mode && (cnt_i == val);
  assign flag_clr = wr_ctl && !reg_wdata_i[B_FLAG] && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl    <= '0;
      flag_o <= 1'b0;
      armed  <= 1'b0;
    end else begin
      if (wr_ctl) ctl <= ctrl_t'(reg_wdata_i[$bits(ctrl_t)-1:0]);
      if (wr_ctl)                  armed <= 1'b0;
      else if (rd_ctl && flag_o)   armed <= 1'b1;
      if (cap_hit || match)        flag_o <= 1'b1;
      else if (flag_clr)           flag_o <= 1'b0;
    end
  end

  tmr_chan_sync #(.STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (cap_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  tmr_chan_val #(.CW(CW)) u_val (
    .clk        (clk),
    .rst_n      (rst_n),
    .buffered_i (ctl.msb),
    .cap_load_i (cap_hit),
    .cnt_i      (cnt_i),
    .wr_i       (wr_val),
    .wdata_i    (reg_wdata_i),
    .ovf_i      (ovf_i),
    .val_o      (val)
  );

  tmr_chan_out u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_i     (ctl),
    .oc_mode_i (oc_mode),
    .match_i   (match),
    .ovf_i     (ovf_i),
    .lvl_o     (pin_lvl),
    .pin_o     (pin_o),
    .oe_o      (pin_oe_o)
  );

  always_comb begin
    if (reg_addr_i) reg_rdata_o = val;
    else            reg_rdata_o = {{PAD_W{1'b0}}, flag_o, 1'b0, ctl};
  end
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
  import tmr_chan_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input ctrl_t         ctl,
  input logic          cap_mode,
  input logic          oc_mode,
  input logic          match,
  input logic          cap_hit,
  input logic          ovf_i,
  input logic [CW-1:0] cnt_i,
  input logic [CW-1:0] val,
  input logic          pin_lvl,
  input logic          pin_o,
  input logic          flag_o
);
  // R2: with els at 00 the level settles to msa
  p_preset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ({ctl.elsb, ctl.elsa} == 2'b00) |=> (pin_lvl == $past(ctl.msa)));

  // R3: a selected edge loads the count and raises the flag
  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> (flag_o && val == $past(cnt_i)));

  // R6: every compare match raises the flag
  p_match_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag_o);

  // R7: overflow leaves the pin alone in capture mode
  p_cap_tov_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode && ({ctl.elsb, ctl.elsa} != 2'b00) && ovf_i) |=> $stable(pin_lvl));

  // R8: overflow toggle beats a same-cycle compare action
  p_tie_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_mode && ({ctl.elsb, ctl.elsa} != 2'b00) && ctl.tov && ovf_i && match)
    |=> (pin_lvl != $past(pin_lvl)));

  // R9: buffered value only moves on overflow
  p_buffer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.msb && !ovf_i) |=> $stable(val));

  // R10: forced high one cycle after fmax with tov
  p_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl.fmax) && ctl.tov) |-> pin_o);

  logic unused_ok;
  assign unused_ok = ^{ctl.msb, ctl.msa};
endmodule

bind tmr_chan tmr_chan_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctl      (ctl),
  .cap_mode (cap_mode),
  .oc_mode  (oc_mode),
  .match    (match),
  .cap_hit  (cap_hit),
  .ovf_i    (ovf_i),
  .cnt_i    (cnt_i),
  .val      (val),
  .pin_lvl  (pin_lvl),
  .pin_o    (pin_o),
  .flag_o   (flag_o)
);

// File: tb/sim_tmr_chan.sv
`timescale 1ns/1ps
module sim_tmr_chan;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cnt_i = '0;
  logic          ovf_i = 1'b0;
  logic          cap_i = 1'b0;
  logic          reg_wr_i = 1'b0;
  logic          reg_rd_i = 1'b0;
  logic          reg_addr_i = 1'b0;
  logic [CW-1:0] reg_wdata_i = '0;
  logic [CW-1:0] reg_rdata_o;
  logic          pin_o, pin_oe_o, flag_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tmr_chan #(.CW(CW)) u0 (.*);

  // vector: {preset level, els[1:0], tov, ovf with match, expected pin}
  localparam logic [5:0] VEC [0:7] = '{
    6'b0_01_0_0_1,  // R5 toggle from low
    6'b1_01_0_0_0,  // R5 toggle from high
    6'b1_10_0_0_0,  // R5 clear
    6'b0_11_0_0_1,  // R5 set
    6'b0_10_1_1_1,  // R8 overflow beats clear
    6'b1_11_1_1_0,  // R8 overflow beats set
    6'b0_11_0_1_1,  // R7 overflow ignored without tov
    6'b1_00_0_0_1   // R6 compare only, pin stays preset
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic a, input logic [CW-1:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    step();
    reg_wr_i = 1'b0;
  endtask

  task automatic rd0();
    reg_rd_i = 1'b1; reg_addr_i = 1'b0;
    step();
    reg_rd_i = 1'b0;
  endtask

  task automatic clr_flag(input logic [CW-1:0] ctl);
    rd0();
    wr(1'b0, ctl);
  endtask

  task automatic rd_val(output logic [CW-1:0] v);
    reg_addr_i = 1'b1; #1; v = reg_rdata_o;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] rv;
    step(); step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    reg_addr_i = 1'b0; #1;
    chk("R1 ctrl", reg_rdata_o, 0);
    chk("R1 pin", pin_o, 0);
    chk("R1 oe", pin_oe_o, 0);
    chk("R1 flag", flag_o, 0);

    // table walk: R5 R6 R7 R8 R11
    for (int i = 0; i < 8; i++) begin
      logic [5:0] v;
      logic [CW-1:0] mode;
      v = VEC[i];
      cnt_i = '0; ovf_i = 1'b0;
      wr(1'b1, 16'd5);
      clr_flag({13'd0, v[5], 2'b00});
      mode = {11'd0, v[2], 1'b0, 1'b1, v[4:3]};
      wr(1'b0, mode);
      chk("R11 flag cleared", flag_o, 0);
      cnt_i = 16'd5; ovf_i = v[1];
      step();
      cnt_i = 16'd6; ovf_i = 1'b0;
      chk("R5/R8 pin", pin_o, v[0]);
      chk("R6 flag on match", flag_o, 1);
      chk("R5 oe", pin_oe_o, (v[4:3] != 2'b00));
    end

    // R2 preset levels
    cnt_i = '0;
    wr(1'b0, 16'h0004); step();
    chk("R2 preset high", pin_o, 1);
    chk("R2 oe released", pin_oe_o, 0);
    wr(1'b0, 16'h0000); step();
    chk("R2 preset low", pin_o, 0);

    // R10 force max duty
    wr(1'b0, 16'h0016); step();
    chk("R10 base", pin_o, 0);
    wr(1'b0, 16'h0036);
    chk("R10 not yet", pin_o, 0);
    step();
    chk("R10 forced", pin_o, 1);
    wr(1'b0, 16'h0016);
    chk("R10 held", pin_o, 1);
    step();
    chk("R10 released", pin_o, 0);
    wr(1'b0, 16'h0026); step(); step();
    chk("R10 no tov", pin_o, 0);

    // R7 overflow toggle, then ignored in capture
    wr(1'b0, 16'h0016);
    ovf_i = 1'b1; step(); ovf_i = 1'b0;
    chk("R7 toggle", pin_o, 1);
    wr(1'b0, 16'h0011);
    ovf_i = 1'b1; step(); ovf_i = 1'b0;
    chk("R7 capture ignores", pin_o, 1);
    chk("R7 capture oe", pin_oe_o, 0);

    // R3 R4 capture edges
    clr_flag(16'h0001);
    cnt_i = 16'h1234; cap_i = 1'b1;
    step(); step();
    chk("R4 not yet", flag_o, 0);
    step();
    chk("R4 flag", flag_o, 1);
    rd_val(rv); chk("R3 rising value", rv, 16'h1234);
    clr_flag(16'h0001);
    cnt_i = 16'h2222; cap_i = 1'b0;
    repeat (4) step();
    chk("R3 falling ignored flag", flag_o, 0);
    rd_val(rv); chk("R3 falling ignored value", rv, 16'h1234);
    wr(1'b0, 16'h0002);
    cap_i = 1'b1; repeat (4) step();
    chk("R3 rise ignored", flag_o, 0);
    cnt_i = 16'h3333; cap_i = 1'b0; repeat (3) step();
    chk("R3 falling flag", flag_o, 1);
    rd_val(rv); chk("R3 falling value", rv, 16'h3333);
    clr_flag(16'h0003);
    cnt_i = 16'h4444; cap_i = 1'b1; repeat (3) step();
    rd_val(rv); chk("R3 both rise", rv, 16'h4444);

    // R11 write without read does not clear
    wr(1'b0, 16'h0003);
    chk("R11 no read no clear", flag_o, 1);
    clr_flag(16'h0003);
    chk("R11 cleared", flag_o, 0);
    cnt_i = 16'h5555; cap_i = 1'b0; repeat (3) step();
    rd_val(rv); chk("R3 both fall", rv, 16'h5555);

    // R9 buffered compare
    cnt_i = '0;
    wr(1'b0, 16'h0000);
    wr(1'b1, 16'd9);
    wr(1'b0, 16'h0009);
    wr(1'b1, 16'd5);
    rd_val(rv); chk("R9 still old", rv, 16'd9);
    clr_flag(16'h0009);
    cnt_i = 16'd5; step(); cnt_i = '0;
    chk("R9 no early match", flag_o, 0);
    ovf_i = 1'b1; step(); ovf_i = 1'b0;
    rd_val(rv); chk("R9 loaded at overflow", rv, 16'd5);
    cnt_i = 16'd5; step(); cnt_i = '0;
    chk("R9 match after load", flag_o, 1);
    reg_addr_i = 1'b0; #1;
    chk("R12 word0 layout", reg_rdata_o, 16'h0089);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule